// File: doc/BRIEF.md
# Load/Store Alignment and Byte-Order Unit

This unit sits between the load/store stage of a core and a data memory port that only accepts naturally aligned beats as wide as the data path. Each request carries an address, an access size of 1, 2, 4 or 8 bytes, a read/write flag, a Device-versus-Normal memory flag, a strict-alignment enable, a big-endian enable and an instruction-fetch flag. The unit first decides whether the access is legal. An illegal access is answered straight away with an alignment fault and never reaches memory. A legal access goes out as one or two aligned 8-byte beats, each with a byte-enable mask.

An unaligned Normal access that crosses an 8-byte boundary is split into a lower beat and an upper beat, and the returned bytes are merged. Either beat can be aborted by the memory, and the reply says which beat failed. Big-endian data accesses are byte-reversed within their own size. Instruction fetches are always read as 32-bit little-endian words.

Control is a six-state machine. ST_IDLE accepts a request and moves to ST_REPLY on an alignment fault, or to ST_ISSUE_LO otherwise. ST_ISSUE_LO moves to ST_WAIT_LO when the memory takes the beat. ST_WAIT_LO moves on the memory response: to ST_REPLY on an abort, to ST_ISSUE_HI when the access is split, and to ST_REPLY otherwise. ST_ISSUE_HI moves to ST_WAIT_HI when its beat is taken. ST_WAIT_HI moves to ST_REPLY on the memory response. ST_REPLY returns to ST_IDLE when the reply is taken.

Top module: `lsu_align_unit`

## Requirements
- R1: A legal access that fits inside one 8-byte block issues one beat at the address rounded down to a multiple of 8. Its byte-enable bit k is set for each byte k = offset .. offset+n-1, where offset = address mod 8 and n is the byte count.
- R2: An instruction fetch (req_ifetch=1) is always a 4-byte little-endian read, and req_size, req_write and req_big_endian have no effect on it. A fetch whose address is not a multiple of 4 replies with rsp_fault=1 (alignment) and issues no beat.
- R3: A data access is unaligned when its address is not a multiple of its size. Sizes are encoded 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. An unaligned access with req_device=1 replies with rsp_fault=1 and issues no beat, whatever req_strict_align is, and a faulting store changes no memory byte. An aligned Device access is performed.
- R4: An unaligned Normal access faults (rsp_fault=1, no beat) when req_strict_align=1, and is performed when req_strict_align=0.
- R5: A performed access whose bytes cross an 8-byte boundary issues two beats: first the lower block, then the block 8 bytes above it. A beat is held unchanged until mem_ready. An unaligned access that stays inside one block issues a single beat.
- R6: When the memory answers a beat with mem_rsp_err=1, the reply carries rsp_fault=2 (beat abort) and rsp_fault_beat=0 for the lower beat or 1 for the upper beat. An abort on the lower beat stops the upper beat from being issued.
- R7: For data accesses with req_big_endian=1, the bytes are reversed within the access size: within 16 bits, 32 bits or 64 bits. Store data is reversed before it is placed into the beats, and load data is reversed after it has been merged. Byte-sized accesses are never changed.
- R8: Little-endian load data holds in byte i the memory byte at address+i, and is zero-extended above the access size. rsp_rdata is zero for stores and for faulted accesses.
- R9: Only one access is in flight at a time. req_ready falls after a request is accepted and rises again after the reply handshake. The reply is valid 1 cycle after acceptance for an alignment fault, 3 cycles after for a one-beat access and 5 cycles after for a two-beat access, given a memory that is always ready and answers in the following cycle.
- R10: After reset, req_ready=1, mem_valid=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_write | input | 1 | 1 for a store |
| req_device | input | 1 | 1 for Device memory, 0 for Normal |
| req_strict_align | input | 1 | Fault unaligned Normal accesses |
| req_big_endian | input | 1 | Data is big-endian |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_wdata | input | DW | Store value, right-justified |
| mem_valid | output | 1 | Beat valid |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | AW | Beat address, 8-byte aligned |
| mem_write | output | 1 | Beat is a write |
| mem_be | output | DW/8 | Byte enables of the beat |
| mem_wdata | output | DW | Beat write data, lane-placed |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | DW | Memory read data of the beat |
| mem_rsp_err | input | 1 | Memory aborted the beat |
| rsp_valid | output | 1 | Reply valid |
| rsp_ready | input | 1 | Pipeline takes the reply |
| rsp_rdata | output | DW | Load result, zero-extended |
| rsp_fault | output | 2 | 0 none, 1 alignment, 2 beat abort |
| rsp_fault_beat | output | 1 | Aborted beat: 0 lower, 1 upper |

## Verification
A request is accepted at a rising edge. An alignment-fault reply is visible one cycle later. With the bench memory, which is always ready and drives its response on the falling edge after it takes a beat, a one-beat reply is visible three cycles after acceptance and a two-beat reply five cycles after. The bench counts falling edges from the accepting edge and samples rsp_valid, rsp_fault, rsp_rdata and req_ready only on those falling edges, so the measured latency itself is compared with 1, 3 or 5. Beat addresses and memory contents are recorded by the memory model on the same falling edges, and memory is compared byte for byte with a shadow copy after every access.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_WAIT_LO,
        ST_ISSUE_HI,
        ST_WAIT_HI,
        ST_REPLY
    } lsu_state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_ALIGN = 2'd1,
        FLT_BEAT  = 2'd2
    } lsu_fault_e;

    // instruction fetches are always one word wide
    localparam logic [1:0] SZ_FETCH = 2'd2;

endpackage

// File: rtl/lsu_align_judge.sv
// Legality and beat-count decision for an incoming request.
module lsu_align_judge
    import lsu_align_pkg::*;
#(
    parameter int OFFW = 3
) (
    input  logic [OFFW-1:0] off,
    input  logic [1:0]      size,
    input  logic            device,
    input  logic            strict,
    input  logic            ifetch,
    output logic [1:0]      eff_size,
    output logic            align_fault,
    output logic            split
);
    logic [OFFW-1:0] low_mask;
    logic [OFFW:0]   last_byte;
    logic            misalign;

    always_comb begin
        eff_size    = ifetch ? SZ_FETCH : size;
        low_mask    = OFFW'((1 << eff_size) - 1);
        misalign    = |(off & low_mask);
        last_byte   = {1'b0, off} + {1'b0, low_mask};
        split       = last_byte[OFFW];
        align_fault = ifetch ? misalign : (misalign && (device || strict));
    end

endmodule

// File: rtl/lsu_byte_rev.sv
// Keeps the low bytes of the access size, optionally reversing their order.
module lsu_byte_rev #(
    parameter int NB = 8
) (
    input  logic [NB*8-1:0] din,
    input  logic [1:0]      size,
    input  logic            en,
    output logic [NB*8-1:0] dout
);
    int               nbytes;
    logic [NB*8-1:0]  keep;

    assign nbytes = 1 << size;

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic [7:0] straight;
        logic [7:0] flipped;

        assign straight = din[j*8 +: 8];

        always_comb begin
            flipped = 8'h00;
            for (int k = 0; k < NB; k++) begin
                if (k == nbytes - 1 - j) begin
                    flipped = din[k*8 +: 8];
                end
            end
        end

        assign keep[j*8 +: 8] = (j < nbytes) ? straight : 8'h00;
        assign dout[j*8 +: 8] = (j < nbytes) ? (en ? flipped : straight) : 8'h00;
    end

    // R7: reversal only moves bytes, so the set bit count is unchanged
    always_comb begin
        p_rev_keeps_bits_r7: assert ($countones(dout) == $countones(keep));
    end

endmodule

// File: rtl/lsu_lane_place.sv
// Places a right-justified store value and its byte mask into a two-block window.
module lsu_lane_place #(
    parameter int NB   = 8,
    parameter int OFFW = 3
) (
    input  logic [NB*8-1:0]   data,
    input  logic [1:0]        size,
    input  logic [OFFW-1:0]   off,
    output logic [2*NB*8-1:0] win,
    output logic [2*NB-1:0]   be
);
    logic [NB-1:0] base_mask;

    assign base_mask = NB'((1 << (1 << size)) - 1);
    assign win       = {{(NB*8){1'b0}}, data} << {off, 3'b000};
    assign be        = {{NB{1'b0}}, base_mask} << off;

endmodule

// File: rtl/lsu_lane_gather.sv
// Pulls the bytes of an access out of the two-block window of returned data.
module lsu_lane_gather #(
    parameter int NB   = 8,
    parameter int OFFW = 3
) (
    input  logic [2*NB*8-1:0] win,
    input  logic [OFFW-1:0]   off,
    output logic [NB*8-1:0]   data
);
    logic [2*NB*8-1:0] shifted;

    assign shifted = win >> {off, 3'b000};
    assign data    = shifted[NB*8-1:0];

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [1:0]      req_size,
    input  logic            req_write,
    input  logic            req_device,
    input  logic            req_strict_align,
    input  logic            req_big_endian,
    input  logic            req_ifetch,
    input  logic [DW-1:0]   req_wdata,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_write,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [DW-1:0]   rsp_rdata,
    output logic [1:0]      rsp_fault,
    output logic            rsp_fault_beat
);
    localparam int NB   = DW / 8;
    localparam int OFFW = $clog2(NB);
    localparam int WINW = 2 * DW;

    lsu_state_e      state_q, state_d;

    logic [AW-1:0]   addr_q;
    logic [1:0]      size_q;
    logic            write_q;
    logic            rev_q;
    logic            split_q;
    logic [DW-1:0]   wdat_q;
    lsu_fault_e      fkind_q;
    logic            fbeat_q;
    logic [DW-1:0]   lo_q;
    logic [DW-1:0]   hi_q;

    logic            accept;
    logic [1:0]      eff_size;
    logic            align_fault;
    logic            split;
    logic [DW-1:0]   st_swapped;
    logic [WINW-1:0] st_win;
    logic [2*NB-1:0] st_be;
    logic [DW-1:0]   ld_merged;
    logic [DW-1:0]   ld_value;
    logic [AW-1:0]   lo_base;

    assign accept  = req_valid && req_ready;
    assign lo_base = {addr_q[AW-1:OFFW], {OFFW{1'b0}}};

    lsu_align_judge #(.OFFW(OFFW)) u_judge (
        .off         (req_addr[OFFW-1:0]),
        .size        (req_size),
        .device      (req_device),
        .strict      (req_strict_align),
        .ifetch      (req_ifetch),
        .eff_size    (eff_size),
        .align_fault (align_fault),
        .split       (split)
    );

    lsu_byte_rev #(.NB(NB)) u_st_rev (
        .din  (req_wdata),
        .size (eff_size),
        .en   (req_big_endian && !req_ifetch),
        .dout (st_swapped)
    );

    lsu_lane_place #(.NB(NB), .OFFW(OFFW)) u_place (
        .data (wdat_q),
        .size (size_q),
        .off  (addr_q[OFFW-1:0]),
        .win  (st_win),
        .be   (st_be)
    );

    lsu_lane_gather #(.NB(NB), .OFFW(OFFW)) u_gather (
        .win  ({hi_q, lo_q}),
        .off  (addr_q[OFFW-1:0]),
        .data (ld_merged)
    );

    lsu_byte_rev #(.NB(NB)) u_ld_rev (
        .din  (ld_merged),
        .size (size_q),
        .en   (rev_q),
        .dout (ld_value)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = align_fault ? ST_REPLY : ST_ISSUE_LO;
                end
            end
            ST_ISSUE_LO: begin
                if (mem_ready) state_d = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err)  state_d = ST_REPLY;
                    else if (split_q) state_d = ST_ISSUE_HI;
                    else              state_d = ST_REPLY;
                end
            end
            ST_ISSUE_HI: begin
                if (mem_ready) state_d = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (mem_rsp_valid) state_d = ST_REPLY;
            end
            ST_REPLY: begin
                if (rsp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // access context and returned data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
            rev_q   <= 1'b0;
            split_q <= 1'b0;
            wdat_q  <= '0;
            fkind_q <= FLT_NONE;
            fbeat_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                size_q  <= eff_size;
                write_q <= req_write && !req_ifetch;
                rev_q   <= req_big_endian && !req_ifetch;
                split_q <= split;
                wdat_q  <= st_swapped;
                fkind_q <= align_fault ? FLT_ALIGN : FLT_NONE;
                fbeat_q <= 1'b0;
                lo_q    <= '0;
                hi_q    <= '0;
            end
            if (state_q == ST_WAIT_LO && mem_rsp_valid) begin
                if (mem_rsp_err) begin
                    fkind_q <= FLT_BEAT;
                    fbeat_q <= 1'b0;
                end else begin
                    lo_q <= mem_rsp_data;
                end
            end
            if (state_q == ST_WAIT_HI && mem_rsp_valid) begin
                if (mem_rsp_err) begin
                    fkind_q <= FLT_BEAT;
                    fbeat_q <= 1'b1;
                end else begin
                    hi_q <= mem_rsp_data;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        mem_valid      = (state_q == ST_ISSUE_LO) || (state_q == ST_ISSUE_HI);
        mem_write      = write_q;
        mem_addr       = lo_base;
        mem_be         = st_be[NB-1:0];
        mem_wdata      = st_win[DW-1:0];
        if (state_q == ST_ISSUE_HI) begin
            mem_addr  = lo_base + AW'(NB);
            mem_be    = st_be[2*NB-1:NB];
            mem_wdata = st_win[WINW-1:DW];
        end
        rsp_valid      = (state_q == ST_REPLY);
        rsp_fault      = fkind_q;
        rsp_fault_beat = fbeat_q;
        rsp_rdata      = (fkind_q == FLT_NONE && !write_q) ? ld_value : '0;
    end

    // checker bookkeeping: beats taken for this access, address of the lower beat
    logic [1:0]    beats_q;
    logic [AW-1:0] lo_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q   <= 2'd0;
            lo_seen_q <= '0;
        end else if (accept) begin
            beats_q <= 2'd0;
        end else if (mem_valid && mem_ready) begin
            beats_q <= beats_q + 2'd1;
            if (beats_q == 2'd0) lo_seen_q <= mem_addr;
        end
    end

    p_align_no_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_ALIGN) |-> beats_q == 2'd0);

    p_lo_abort_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_BEAT && !rsp_fault_beat) |-> beats_q == 2'd1);

    p_hi_above_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && beats_q == 2'd1) |-> mem_addr == lo_seen_q + AW'(NB));

    p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)));

    p_be_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_be != '0);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb;
    localparam int CLK_NS = 10;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int NV = 17;

    // {addr, size, write, device, strict, big, ifetch, exp_fault, exp_beats}
    localparam logic [18:0] VEC [NV] = '{
        {8'h10, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1},
        {8'h22, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1},
        {8'h24, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1},
        {8'h18, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1},
        {8'h31, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1},
        {8'h43, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1},
        {8'h45, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2},
        {8'h4B, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2},
        {8'h53, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0},
        {8'h53, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd0},
        {8'h52, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1},
        {8'h62, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0},
        {8'h64, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1},
        {8'h5F, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2},
        {8'h6D, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2},
        {8'h70, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1},
        {8'h7B, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_size = '0;
    logic            req_write = 1'b0;
    logic            req_device = 1'b0;
    logic            req_strict_align = 1'b0;
    logic            req_big_endian = 1'b0;
    logic            req_ifetch = 1'b0;
    logic [DW-1:0]   req_wdata = '0;
    logic            mem_valid;
    logic            mem_ready = 1'b1;
    logic [AW-1:0]   mem_addr;
    logic            mem_write;
    logic [DW/8-1:0] mem_be;
    logic [DW-1:0]   mem_wdata;
    logic            mem_rsp_valid = 1'b0;
    logic [DW-1:0]   mem_rsp_data = '0;
    logic            mem_rsp_err = 1'b0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b1;
    logic [DW-1:0]   rsp_rdata;
    logic [1:0]      rsp_fault;
    logic            rsp_fault_beat;

    int total = 0;
    int bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    lsu_align_unit #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_device(req_device),
        .req_strict_align(req_strict_align), .req_big_endian(req_big_endian),
        .req_ifetch(req_ifetch), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_fault(rsp_fault), .rsp_fault_beat(rsp_fault_beat)
    );

    // memory model: 32 blocks of 8 bytes, answers on the falling edge after a beat is taken
    logic [63:0] mem [32];
    logic [7:0]  shadow [256];
    bit          pend = 0;
    bit          perr = 0;
    logic [4:0]  pidx = '0;
    bit          err_en = 0;
    logic [4:0]  err_idx = '0;
    int          nbeats = 0;
    logic [7:0]  beat_addr [2];

    always @(negedge clk) begin
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[pidx];
            mem_rsp_err   = perr;
            pend = 0;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
        end
        if (rst_n && mem_valid && mem_ready) begin
            pidx = mem_addr[7:3];
            perr = err_en && (mem_addr[7:3] == err_idx);
            if (nbeats < 2) beat_addr[nbeats] = mem_addr[7:0];
            nbeats++;
            if (mem_write && !perr) begin
                for (int k = 0; k < 8; k++) begin
                    if (mem_be[k]) mem[pidx][k*8 +: 8] = mem_wdata[k*8 +: 8];
                end
            end
            pend = 1;
        end
    end

    task automatic check(input bit ok, input string tg, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0:             return "R8";
            1, 2, 3, 4:    return "R7";
            5, 9:          return "R4";
            6, 7, 13:      return "R5";
            8, 10, 16:     return "R3";
            11, 12:        return "R2";
            default:       return "R7";
        endcase
    endfunction

    task automatic check_memory(input string tg);
        int diffs;
        diffs = 0;
        for (int a = 0; a < 256; a++) begin
            if (mem[a[7:3]][a[2:0]*8 +: 8] != shadow[a]) diffs++;
        end
        check(diffs == 0, tg, "memory bytes differing from shadow", 64'(diffs), 64'd0);
    endtask

    task automatic run(input logic [7:0] a, input logic [1:0] sz, input logic wr,
                       input logic dev, input logic strict, input logic big, input logic ife,
                       input logic [63:0] wd, input logic [1:0] ef, input int eb,
                       input logic efb, input string tg);
        int n;
        int lat;
        bit seen;
        logic [63:0] exp_v;
        logic [63:0] got_v;
        logic [1:0]  got_f;
        logic        got_b;
        logic [7:0]  b;
        logic [7:0]  base;
        int          exp_lat;

        n = ife ? 4 : (1 << sz);
        exp_v = '0;
        for (int i = 0; i < n; i++) begin
            b = shadow[8'(a + i)];
            if (big && !ife) exp_v[(n-1-i)*8 +: 8] = b;
            else             exp_v[i*8 +: 8] = b;
        end
        base = {a[7:3], 3'b000};
        exp_lat = (ef == 2'd1) ? 1 : 1 + 2 * eb;

        @(negedge clk);
        nbeats = 0;
        req_addr = AW'(a); req_size = sz; req_write = wr; req_device = dev;
        req_strict_align = strict; req_big_endian = big; req_ifetch = ife;
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);

        seen = 0; lat = 0; got_v = '0; got_f = '0; got_b = 1'b0;
        for (int t = 1; t <= 20 && !seen; t++) begin
            if (t > 1) @(negedge clk);
            if (rsp_valid) begin
                seen = 1; lat = t;
                got_v = rsp_rdata; got_f = rsp_fault; got_b = rsp_fault_beat;
            end
        end
        check(seen, "R9", "reply seen", 64'(seen), 64'd1);
        check(lat == exp_lat, "R9", "reply latency", 64'(lat), 64'(exp_lat));
        check(got_f == ef, tg, "fault kind", 64'(got_f), 64'(ef));
        check(nbeats == eb, (eb == 2) ? "R5" : tg, "beat count", 64'(nbeats), 64'(eb));
        if (ef == 2'd2) check(got_b == efb, "R6", "aborted beat", 64'(got_b), 64'(efb));
        if (nbeats >= 1) check(beat_addr[0] == base, "R1", "lower beat address",
                               64'(beat_addr[0]), 64'(base));
        if (nbeats == 2) check(beat_addr[1] == base + 8'd8, "R5", "upper beat address",
                               64'(beat_addr[1]), 64'(base + 8'd8));
        if (ef == 2'd0 && (!wr || ife))
            check(got_v == exp_v, tg, "load data", got_v, exp_v);
        else
            check(got_v == 64'd0, "R8", "rdata of store or fault", got_v, 64'd0);

        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready after reply", 64'(req_ready), 64'd1);

        if (wr && !ife && ef == 2'd0) begin
            for (int i = 0; i < n; i++) begin
                if (big) shadow[8'(a + i)] = wd[(n-1-i)*8 +: 8];
                else     shadow[8'(a + i)] = wd[i*8 +: 8];
            end
        end
        check_memory(tg);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            shadow[a] = 8'(a) ^ 8'h3C;
            mem[a[7:3]][a[2:0]*8 +: 8] = 8'(a) ^ 8'h3C;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready == 1'b1, "R10", "req_ready in reset", 64'(req_ready), 64'd1);
        check(mem_valid == 1'b0, "R10", "mem_valid in reset", 64'(mem_valid), 64'd0);
        check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_valid == 1'b0, "R10", "idle after reset",
              64'({req_ready, mem_valid}), 64'b10);

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VEC[i];
            run(v[18:11], v[10:9], v[8], v[7], v[6], v[5], v[4],
                64'h0123_4567_89AB_CDEF ^ {8{8'(i)}}, v[3:2], int'(v[1:0]), 1'b0, tag_of(i));
        end

        // R6: abort on the upper beat of a split load
        err_en = 1; err_idx = 5'h11;
        run(8'h85, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 2'd2, 2, 1'b1, "R6");
        // R6: abort on the lower beat stops the upper beat
        err_idx = 5'h12;
        run(8'h95, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 2'd2, 1, 1'b0, "R6");
        // R6: aborted lower beat of a split store leaves memory unchanged
        err_idx = 5'h14;
        run(8'hA6, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'hDEAD_BEEF, 2'd2, 1, 1'b0, "R6");
        err_en = 0;
        // R4: the same unaligned Normal load performs once strict checking is off
        run(8'h53, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 64'd0, 2'd0, 1, 1'b0, "R4");
        // R8: little-endian split doubleword, zero-extension of a half
        run(8'hB7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 2'd0, 2, 1'b0, "R8");
        run(8'hC6, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 2'd0, 1, 1'b0, "R8");
        // R7: big-endian byte store is not reversed
        run(8'hD3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'h00AB, 2'd0, 1, 1'b0, "R7");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule